// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the sequence of column addresses that a synchronous DRAM burst walks through. A controller, or a behavioural memory model, presents a start column together with a one-cycle command strobe. From the following cycle on, the generator outputs one column address per clock, with a valid flag and a flag that marks the final beat. The mode settings (burst length, ordering and write-burst policy) are captured when the command is accepted, so they can change on the pins while a burst is running without disturbing it.

Fixed bursts of 1, 2, 4 or 8 beats move only the low bits of the column and leave the upper bits alone. The low bits either count up with wrap-around or are the start bits XORed with the beat number. A full-page burst steps through every column of a row, wrapping from the top column back to zero, and keeps going until a terminate strobe or a new command arrives. A policy bit can limit writes to a single beat while reads still use the programmed burst. A new command may arrive on any clock and restarts the sequence at once.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and until the first command, `colValid` and `colLast` are both 0.
- R2: When `cmdStart` is 1 at a clock edge, on the next cycle `colValid` is 1 and `colAddr` equals the `startCol` presented with it. This holds even if a burst is already running, so a command can be accepted on every cycle.
- R3: With `modeLen` = 3'b001, 3'b010 or 3'b011 (2, 4 or 8 beats) and `modeInterleave` = 0, beat k has its low log2(BL) bits equal to (start + k) mod BL. The remaining upper bits equal the start column.
- R4: With the same lengths and `modeInterleave` = 1, beat k has its low log2(BL) bits equal to the start low bits XOR k. The upper bits are unchanged.
- R5: `modeLen` = 3'b000 gives a one-beat burst. The unused codes 3'b100, 3'b101 and 3'b110 also give one beat.
- R6: `modeLen` = 3'b111 gives a full-page burst. Its addresses count up from the start column whatever the value of `modeInterleave`, and wrap from 255 to 0. The burst runs past 256 beats until it is terminated or replaced, and `colLast` stays 0 for its whole length.
- R7: In a fixed-length burst, `colLast` is 1 only on the final beat. On the cycle after that beat, `colValid` is 0 unless a new command was accepted.
- R8: With `modeSingleWrite` = 1, a command with `cmdIsWrite` = 1 makes a one-beat burst for any length code. A command with `cmdIsWrite` = 0 keeps the programmed length and order.
- R9: When `termStrobe` is 1 at an edge with `cmdStart` at 0, `colValid` is 0 from the next cycle on. If both strobes are 1 together, the command wins.
- R10: Mode inputs are sampled only at a command edge. Changing them during a burst leaves that burst's addresses and length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmdStart | input | 1 | Read or write command strobe; starts a burst |
| cmdIsWrite | input | 1 | 1 when the command is a write |
| startCol | input | COL_W | Start column of the command |
| termStrobe | input | 1 | Burst-terminate strobe |
| modeLen | input | 3 | Burst length code |
| modeInterleave | input | 1 | 0 sequential, 1 interleaved ordering |
| modeSingleWrite | input | 1 | 1 limits writes to one beat |
| colAddr | output | COL_W | Current column address |
| colValid | output | 1 | Column address is valid this cycle |
| colLast | output | 1 | Final beat of a fixed-length burst |

## Verification
On every cycle, the assertions check the relations between the strobes and the outputs. A command must show its start column on the next cycle, a terminate without a command must clear valid, and the last-beat flag must always sit inside a valid burst and always be followed by an idle cycle. A burst may not end early, and a single-beat write must be flagged last on its first beat. The exact address orderings need the bench's scenarios, because they depend on the start column and the captured mode. These are sequential and XOR orderings for each length, the full-page wrap past 256 beats, the reserved length codes, and the immunity to mode changes mid-burst.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  typedef enum logic [2:0] {
    LEN_ONE   = 3'b000,
    LEN_TWO   = 3'b001,
    LEN_FOUR  = 3'b010,
    LEN_EIGHT = 3'b011,
    LEN_PAGE  = 3'b111
  } lenCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
  } dpStrb_t;

  // burst shape decoded at command time
  typedef struct packed {
    logic [1:0] lenLog;
    logic       fullPage;
    logic       interleave;
  } burstCfg_t;

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmdStart,
  input  logic      cmdIsWrite,
  input  logic      termStrobe,
  input  logic [2:0] modeLen,
  input  logic      modeInterleave,
  input  logic      modeSingleWrite,
  input  logic      atLast,
  output dpStrb_t   strb,
  output burstCfg_t cfg,
  output logic      colValid
);

  logic burstActive;
  logic activeNext;

  // decode length code, apply single-write policy and page ordering
  always_comb begin
    cfg = '0;
    case (lenCode_e'(modeLen))
      LEN_TWO:   cfg.lenLog = 2'd1;
      LEN_FOUR:  cfg.lenLog = 2'd2;
      LEN_EIGHT: cfg.lenLog = 2'd3;
      LEN_PAGE:  cfg.fullPage = 1'b1;
      default:   cfg.lenLog = 2'd0;
    endcase
    if (cmdIsWrite && modeSingleWrite) begin
      cfg.lenLog   = 2'd0;
      cfg.fullPage = 1'b0;
    end
    cfg.interleave = modeInterleave & ~cfg.fullPage;
  end

  always_comb begin
    activeNext = burstActive;
    if (cmdStart)                 activeNext = 1'b1;
    else if (termStrobe)          activeNext = 1'b0;
    else if (burstActive && atLast) activeNext = 1'b0;
  end

  always_comb begin
    strb.load    = cmdStart;
    strb.advance = burstActive & ~cmdStart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burstActive <= 1'b0;
    else        burstActive <= activeNext;
  end

  assign colValid = burstActive;

endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrb_t          strb,
  input  burstCfg_t        cfg,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colAddr,
  output logic             atLast
);

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] beatIdx;
  logic [1:0]       lenLogQ;
  logic             fullQ;
  logic             interQ;
  logic [COL_W-1:0] burstMask;
  logic [COL_W-1:0] seqSum;
  logic [COL_W-1:0] xorVal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseCol <= '0;
      beatIdx <= '0;
      lenLogQ <= '0;
      fullQ   <= 1'b0;
      interQ  <= 1'b0;
    end else if (strb.load) begin
      baseCol <= startCol;
      beatIdx <= '0;
      lenLogQ <= cfg.lenLog;
      fullQ   <= cfg.fullPage;
      interQ  <= cfg.interleave;
    end else if (strb.advance) begin
      beatIdx <= beatIdx + 1'b1;
    end
  end

  assign seqSum = baseCol + beatIdx;
  assign xorVal = baseCol ^ beatIdx;

  // per-bit: moving bits follow the ordering, others hold the start column
  for (genvar gi = 0; gi < COL_W; gi++) begin : g_bit
    assign burstMask[gi] = fullQ | (32'(gi) < {30'd0, lenLogQ});
    assign colAddr[gi]   = burstMask[gi] ? (interQ ? xorVal[gi] : seqSum[gi])
                                         : baseCol[gi];
  end

  assign atLast = ~fullQ & (beatIdx == burstMask);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdStart,
  input  logic             cmdIsWrite,
  input  logic [COL_W-1:0] startCol,
  input  logic             termStrobe,
  input  logic [2:0]       modeLen,
  input  logic             modeInterleave,
  input  logic             modeSingleWrite,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             colLast
);

  dpStrb_t   strb;
  burstCfg_t cfg;
  logic      atLast;

  burst_col_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdIsWrite(cmdIsWrite),
    .termStrobe(termStrobe), .modeLen(modeLen), .modeInterleave(modeInterleave),
    .modeSingleWrite(modeSingleWrite), .atLast(atLast), .strb(strb), .cfg(cfg),
    .colValid(colValid)
  );

  burst_col_dp #(.COL_W(COL_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cfg(cfg), .startCol(startCol),
    .colAddr(colAddr), .atLast(atLast)
  );

  assign colLast = colValid & atLast;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmdStart,
  input logic             cmdIsWrite,
  input logic [COL_W-1:0] startCol,
  input logic             termStrobe,
  input logic             modeSingleWrite,
  input logic [COL_W-1:0] colAddr,
  input logic             colValid,
  input logic             colLast
);

  assert_start_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmdStart |=> (colValid && colAddr == $past(startCol)));

  assert_term_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (termStrobe && !cmdStart) |=> !colValid);

  assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    colLast |-> colValid);

  assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (colLast && !cmdStart) |=> !colValid);

  assert_no_early_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (colValid && !colLast && !termStrobe) |=> colValid);

  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStart && cmdIsWrite && modeSingleWrite) |=> colLast);

  always_comb begin
    if (!rst_n) assert_reset_idle_R1: assert (!colValid && !colLast);
  end

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdIsWrite(cmdIsWrite),
  .startCol(startCol), .termStrobe(termStrobe), .modeSingleWrite(modeSingleWrite),
  .colAddr(colAddr), .colValid(colValid), .colLast(colLast)
);

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;

  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmdStart = 1'b0;
  logic             cmdIsWrite = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic             termStrobe = 1'b0;
  logic [2:0]       modeLen = 3'b000;
  logic             modeInterleave = 1'b0;
  logic             modeSingleWrite = 1'b0;
  logic [COL_W-1:0] colAddr;
  logic             colValid;
  logic             colLast;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdIsWrite(cmdIsWrite),
    .startCol(startCol), .termStrobe(termStrobe), .modeLen(modeLen),
    .modeInterleave(modeInterleave), .modeSingleWrite(modeSingleWrite),
    .colAddr(colAddr), .colValid(colValid), .colLast(colLast)
  );

  task automatic chk(string req, int act, int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected address of beat k from the ordering rules
  function automatic logic [COL_W-1:0] expAddr(logic [COL_W-1:0] st, int lenLog,
                                               bit full, bit inter, int k);
    logic [COL_W-1:0] msk, low, kk;
    kk = COL_W'(k);
    if (full) return st + kk;
    msk = COL_W'((1 << lenLog) - 1);
    low = inter ? ((st ^ kk) & msk) : ((st + kk) & msk);
    return (st & ~msk) | low;
  endfunction

  // issue a command at a negedge; outputs seen at the next negedge
  task automatic issue(logic [COL_W-1:0] st, logic [2:0] len, bit inter, bit wr, bit sw);
    @(negedge clk);
    startCol = st; modeLen = len; modeInterleave = inter;
    cmdIsWrite = wr; modeSingleWrite = sw; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
  endtask

  task automatic runFixed(string req, logic [COL_W-1:0] st, logic [2:0] len,
                          int lenLog, bit inter, bit wr, bit sw);
    int n;
    n = 1 << lenLog;
    issue(st, len, inter, wr, sw);
    for (int b = 0; b < n; b++) begin
      chk(req, colValid, 1);
      chk(req, colAddr, expAddr(st, lenLog, 1'b0, inter, b));
      chk(req, colLast, (b == n - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk({req, " idle after last R7"}, colValid, 0);
  endtask

  task automatic testReset();
    chk("R1 valid", colValid, 0);
    chk("R1 last", colLast, 0);
  endtask

  task automatic testSequential();
    runFixed("R3 seq BL2", 8'h37, 3'b001, 1, 1'b0, 1'b0, 1'b0);
    runFixed("R3 seq BL4", 8'h4E, 3'b010, 2, 1'b0, 1'b0, 1'b0);
    runFixed("R3 seq BL8", 8'hA6, 3'b011, 3, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testInterleaved();
    runFixed("R4 int BL2", 8'h13, 3'b001, 1, 1'b1, 1'b0, 1'b0);
    runFixed("R4 int BL4", 8'h21, 3'b010, 2, 1'b1, 1'b0, 1'b0);
    runFixed("R4 int BL8", 8'h5D, 3'b011, 3, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testSingleBeat();
    runFixed("R5 BL1", 8'h77, 3'b000, 0, 1'b0, 1'b0, 1'b0);
    runFixed("R5 reserved 100", 8'h12, 3'b100, 0, 1'b1, 1'b0, 1'b0);
    runFixed("R5 reserved 101", 8'h34, 3'b101, 0, 1'b0, 1'b0, 1'b0);
    runFixed("R5 reserved 110", 8'h56, 3'b110, 0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testFullPage();
    issue(8'hFA, 3'b111, 1'b1, 1'b0, 1'b0);
    for (int b = 0; b < 262; b++) begin
      chk("R6 page valid", colValid, 1);
      chk("R6 page addr", colAddr, expAddr(8'hFA, 0, 1'b1, 1'b0, b));
      chk("R6 page no last", colLast, 0);
      if (b < 261) @(negedge clk);
    end
    termStrobe = 1'b1;
    @(negedge clk);
    termStrobe = 1'b0;
    chk("R9 page terminate", colValid, 0);
  endtask

  task automatic testSingleWrite();
    runFixed("R8 write one beat", 8'h6B, 3'b011, 0, 1'b1, 1'b1, 1'b1);
    runFixed("R8 read keeps BL8", 8'h6B, 3'b011, 3, 1'b1, 1'b0, 1'b1);
    runFixed("R8 write page one beat", 8'hC0, 3'b111, 0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic testTerminate();
    issue(8'h30, 3'b011, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 mid-burst addr", colAddr, 8'h32);
    termStrobe = 1'b1;
    @(negedge clk);
    termStrobe = 1'b0;
    chk("R9 valid dropped", colValid, 0);
    chk("R9 last low", colLast, 0);
    // both strobes together: command wins
    issue(8'h40, 3'b011, 1'b0, 1'b0, 1'b0);
    startCol = 8'h91; modeLen = 3'b010; cmdStart = 1'b1; termStrobe = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0; termStrobe = 1'b0;
    chk("R9 command wins valid", colValid, 1);
    chk("R9 command wins addr", colAddr, 8'h91);
    repeat (3) @(negedge clk);
    chk("R9 restart ends", colLast, 1);
    @(negedge clk);
  endtask

  task automatic testRestart();
    // a new command on every cycle
    @(negedge clk);
    modeLen = 3'b011; modeInterleave = 1'b0; cmdIsWrite = 1'b0;
    modeSingleWrite = 1'b0;
    startCol = 8'h10; cmdStart = 1'b1;
    @(negedge clk);
    chk("R2 restart 1", colAddr, 8'h10);
    startCol = 8'hE7;
    @(negedge clk);
    chk("R2 restart 2", colAddr, 8'hE7);
    startCol = 8'h03;
    @(negedge clk);
    cmdStart = 1'b0;
    chk("R2 restart 3", colAddr, 8'h03);
    chk("R2 restart valid", colValid, 1);
    @(negedge clk);
    chk("R2 continues", colAddr, 8'h04);
    repeat (7) @(negedge clk);
    chk("R2 ends", colValid, 0);
  endtask

  task automatic testModeHold();
    issue(8'h2C, 3'b011, 1'b1, 1'b0, 1'b0);
    modeLen = 3'b000; modeInterleave = 1'b0; modeSingleWrite = 1'b1;
    cmdIsWrite = 1'b1;
    for (int b = 0; b < 8; b++) begin
      chk("R10 addr", colAddr, expAddr(8'h2C, 3, 1'b0, 1'b1, b));
      chk("R10 last", colLast, (b == 7) ? 1 : 0);
      @(negedge clk);
    end
    chk("R10 end", colValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testSequential();
    testInterleaved();
    testSingleBeat();
    testFullPage();
    testSingleWrite();
    testTerminate();
    testRestart();
    testModeHold();
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule